// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block runs the external bus of a CPU core on a shared address/data bus. Each core request (address, write data, direction and a 4-bit cycle code) becomes one four-state bus cycle, T1 through T4. In T1 the block lowers the address strobe and puts the address on the bus. In T2 and T3 it drives the read or write strobe, the data-buffer enable and, for writes, the data. In T4 it pulses done. A timing marker output follows the state boundaries, so external logic can track T2 and T4 without decoding the strobes.

The block also gives up the bus to an external DMA master. When hold is requested, the block grants it at the next cycle boundary and stops driving the address, address strobe, direction and status lines. While the hold lasts, it watches the address strobe and direction pins as inputs. For each DMA cycle it produces a fixed-length read or write strobe on the master's behalf.

Top module: `mbc_bus_ctrl`

## Requirements
- R1: While `rst` is high, and in idle after it, the outputs are: `ads_n_o`=1, `rd_o`=`wr_o`=`dbe_o`=`hlda_o`=`done_o`=`ad_oe_o`=0, `tso_o`=1, `dir_read_o`=1, `status_o`=0, and `ads_oe_o`=`dir_oe_o`=`status_oe_o`=1. A reset in the middle of a cycle returns the block to this state.
- R2: A request is taken when `req_valid_i` is high in idle (with `hold_i` low) or at the end of T4. T1 starts on the following cycle. During T1, and only then, `ads_n_o` is 0, `ad_o` carries the address and `ad_oe_o` is 1. T2, T3 and T4 follow on consecutive clocks.
- R3: `tso_o` is 1 in T1, 0 in T2 and T3, and 1 again in T4 and in idle. It therefore falls at the start of T2 and rises at the start of T4.
- R4: In a read cycle (`req_write_i`=0), `dir_read_o` is 1 and `rd_o` is high in T2 and T3. `wr_o` stays low, `ad_oe_o` is 0 after T1, and `rdata_o` holds the value of `ad_i` sampled at the T3-to-T4 edge while `done_o` is high. `rd_o` and `wr_o` are never high together.
- R5: In a write cycle, `dir_read_o` is 0 and `wr_o` is high in T2 and T3. `ad_o` drives the write data with `ad_oe_o`=1 in T2 and T3 and releases the bus in T4.
- R6: `dbe_o` is high exactly in T2 and T3 of a core cycle.
- R7: `done_o` is high for the single T4 clock of each cycle. If a request is waiting at the end of T4, the next T1 follows immediately, with no idle clock between.
- R8: `status_o` carries the request's 4-bit code from T1 through T4 and is 0 in idle. The codes include 4'b1100 (effective-address read), 4'b1101 (slave operand transfer), 4'b1110 (slave status read) and 4'b1111 (slave ID broadcast).
- R9: In idle, `hold_i` takes priority over a pending request, and `hlda_o` rises on the clock after `hold_i` is sampled high.
- R10: A hold raised during T1 to T3 lets the cycle finish through T4. `hlda_o` then rises on the clock after T4.
- R11: While `hlda_o` is 1, `ad_oe_o`, `ads_oe_o`, `dir_oe_o` and `status_oe_o` are 0, and core requests start no cycle. `hlda_o` falls on the clock after `hold_i` is sampled low, and the enables return at that point.
- R12: While held, `ads_n_i`=0 sampled at an edge starts a strobe two clocks long. The strobe is `rd_o` if `dir_read_i`=1 at that edge, otherwise `wr_o`. `ads_n_i` low during an active strobe, or when not held, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid_i | input | 1 | Core request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_status_i | input | STAT_W | Cycle code for the status lines |
| req_addr_i | input | DATA_W | Cycle address |
| req_wdata_i | input | DATA_W | Write data |
| done_o | output | 1 | One-clock pulse in T4 |
| rdata_o | output | DATA_W | Captured read data |
| ad_o | output | DATA_W | Multiplexed bus out |
| ad_oe_o | output | 1 | Bus output enable |
| ad_i | input | DATA_W | Multiplexed bus in |
| ads_n_o | output | 1 | Address strobe, active low |
| ads_oe_o | output | 1 | Address strobe output enable |
| ads_n_i | input | 1 | Address strobe from DMA master, active low |
| dir_read_o | output | 1 | Direction, 1 = read |
| dir_oe_o | output | 1 | Direction output enable |
| dir_read_i | input | 1 | Direction from DMA master, 1 = read |
| rd_o | output | 1 | Read strobe, active high |
| wr_o | output | 1 | Write strobe, active high |
| dbe_o | output | 1 | Data buffer enable |
| tso_o | output | 1 | Timing state marker |
| status_o | output | STAT_W | Cycle status lines |
| status_oe_o | output | 1 | Status output enable |
| hold_i | input | 1 | Bus hold request |
| hlda_o | output | 1 | Hold acknowledge |

## Verification
The vector table walks through several patterns:
- an isolated read, which separates the read strobe timing from the write strobe timing;
- a write followed by a read back to back, which shows whether a request waiting at T4 skips the idle clock;
- a hold raised in mid-cycle, which shows whether the grant waits for T4;
- DMA cycles of both directions, one with a retrigger during an active strobe, which test strobe length and selection;
- address strobes while idle and on the entry edge, which must not start a strobe.

Directed runs then cover the four status codes and distinct data patterns on reads and writes, so that the bus contents, the direction and the captured read data are told apart. Two further runs cover the output enables during a hold and a reset in mid-cycle.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  typedef enum logic [2:0] {
    BS_IDLE = 3'd0,
    BS_T1   = 3'd1,
    BS_T2   = 3'd2,
    BS_T3   = 3'd3,
    BS_T4   = 3'd4,
    BS_HELD = 3'd5
  } bus_state_e;

  function automatic logic in_data_phase(input bus_state_e s);
    return (s == BS_T2) || (s == BS_T3);
  endfunction

  function automatic logic in_cycle(input bus_state_e s);
    return (s == BS_T1) || (s == BS_T2) || (s == BS_T3) || (s == BS_T4);
  endfunction
endpackage

// File: rtl/mbc_seq.sv
module mbc_seq
  import mbc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int STAT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [STAT_W-1:0] req_status_i,
  input  logic [DATA_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              hold_i,
  output bus_state_e        state_q,
  output bus_state_e        state_d,
  output logic              cur_write,
  output logic [STAT_W-1:0] cur_status,
  output logic [DATA_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_wdata
);
  logic              lat_write;
  logic [STAT_W-1:0] lat_status;
  logic [DATA_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;
  logic              accept;

  always_comb begin
    state_d = state_q;
    case (state_q)
      BS_IDLE: begin
        if (hold_i)           state_d = BS_HELD;
        else if (req_valid_i) state_d = BS_T1;
      end
      BS_T1:   state_d = BS_T2;
      BS_T2:   state_d = BS_T3;
      BS_T3:   state_d = BS_T4;
      BS_T4: begin
        if (hold_i)           state_d = BS_HELD;
        else if (req_valid_i) state_d = BS_T1;
        else                  state_d = BS_IDLE;
      end
      BS_HELD: if (!hold_i)   state_d = BS_IDLE;
      default:                state_d = BS_IDLE;
    endcase
  end

  assign accept = (state_d == BS_T1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= BS_IDLE;
      lat_write  <= 1'b0;
      lat_status <= '0;
      lat_addr   <= '0;
      lat_wdata  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        lat_write  <= req_write_i;
        lat_status <= req_status_i;
        lat_addr   <= req_addr_i;
        lat_wdata  <= req_wdata_i;
      end
    end
  end

  assign cur_write  = accept ? req_write_i  : lat_write;
  assign cur_status = accept ? req_status_i : lat_status;
  assign cur_addr   = accept ? req_addr_i   : lat_addr;
  assign cur_wdata  = accept ? req_wdata_i  : lat_wdata;

  assert_t1_to_t2_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == BS_T1) |=> (state_q == BS_T2));
  assert_t2_to_t3_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == BS_T2) |=> (state_q == BS_T3));
  assert_hold_waits_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q == BS_T3) |=> (state_q == BS_T4));
endmodule

// File: rtl/mbc_dma.sv
module mbc_dma #(
  parameter int STB_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic held_q,
  input  logic held_d,
  input  logic ads_n_i,
  input  logic dir_read_i,
  output logic rd_o,
  output logic wr_o
);
  localparam int CW = (STB_LEN > 1) ? $clog2(STB_LEN) : 1;
  localparam logic [CW-1:0] CNT_INIT = CW'(STB_LEN - 1);

  logic [CW-1:0] remain;
  logic          active;

  assign active = rd_o | wr_o;

  always_ff @(posedge clk) begin
    if (rst || !held_d) begin
      rd_o   <= 1'b0;
      wr_o   <= 1'b0;
      remain <= '0;
    end else if (active) begin
      if (remain == '0) begin
        rd_o <= 1'b0;
        wr_o <= 1'b0;
      end else begin
        remain <= remain - 1'b1;
      end
    end else if (held_q && !ads_n_i) begin
      rd_o   <= dir_read_i;
      wr_o   <= !dir_read_i;
      remain <= CNT_INIT;
    end
  end

  assert_dma_only_held_R12: assert property (@(posedge clk) disable iff (rst)
    (rd_o || wr_o) |-> held_q);
  assert_dma_start_R12: assert property (@(posedge clk) disable iff (rst)
    ($rose(rd_o) || $rose(wr_o)) |-> $past(!ads_n_i));
  assert_dma_excl_R12: assert property (@(posedge clk) disable iff (rst)
    !(rd_o && wr_o));
endmodule

// File: rtl/mbc_pins.sv
module mbc_pins
  import mbc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int STAT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_state_e        state_q,
  input  bus_state_e        state_d,
  input  logic              cur_write,
  input  logic [STAT_W-1:0] cur_status,
  input  logic [DATA_W-1:0] cur_addr,
  input  logic [DATA_W-1:0] cur_wdata,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic              ads_n_o,
  output logic              ads_oe_o,
  output logic              dir_read_o,
  output logic              dir_oe_o,
  output logic              rd_cyc_o,
  output logic              wr_cyc_o,
  output logic              dbe_o,
  output logic              tso_o,
  output logic [STAT_W-1:0] status_o,
  output logic              status_oe_o,
  output logic              hlda_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic nxt_data, nxt_cyc, nxt_held;

  assign nxt_data = in_data_phase(state_d);
  assign nxt_cyc  = in_cycle(state_d);
  assign nxt_held = (state_d == BS_HELD);

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_o        <= '0;
      ad_oe_o     <= 1'b0;
      ads_n_o     <= 1'b1;
      ads_oe_o    <= 1'b1;
      dir_read_o  <= 1'b1;
      dir_oe_o    <= 1'b1;
      rd_cyc_o    <= 1'b0;
      wr_cyc_o    <= 1'b0;
      dbe_o       <= 1'b0;
      tso_o       <= 1'b1;
      status_o    <= '0;
      status_oe_o <= 1'b1;
      hlda_o      <= 1'b0;
      done_o      <= 1'b0;
      rdata_o     <= '0;
    end else begin
      ads_n_o <= (state_d != BS_T1);
      if (state_d == BS_T1) begin
        ad_o    <= cur_addr;
        ad_oe_o <= 1'b1;
      end else if (nxt_data && cur_write) begin
        ad_o    <= cur_wdata;
        ad_oe_o <= 1'b1;
      end else begin
        ad_o    <= '0;
        ad_oe_o <= 1'b0;
      end
      dir_read_o  <= nxt_cyc ? !cur_write : 1'b1;
      rd_cyc_o    <= nxt_data && !cur_write;
      wr_cyc_o    <= nxt_data && cur_write;
      dbe_o       <= nxt_data;
      tso_o       <= !nxt_data;
      status_o    <= nxt_cyc ? cur_status : '0;
      hlda_o      <= nxt_held;
      ads_oe_o    <= !nxt_held;
      dir_oe_o    <= !nxt_held;
      status_oe_o <= !nxt_held;
      done_o      <= (state_d == BS_T4);
      if (state_q == BS_T3 && !cur_write) rdata_o <= ad_i;
    end
  end

  assert_held_release_R11: assert property (@(posedge clk) disable iff (rst)
    hlda_o |-> (!ad_oe_o && !ads_oe_o && !status_oe_o && !dir_oe_o));
  assert_tso_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(tso_o) |-> dbe_o);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_dbe_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    dbe_o |-> (rd_cyc_o || wr_cyc_o));
endmodule

// File: rtl/mbc_bus_ctrl.sv
module mbc_bus_ctrl
  import mbc_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int STAT_W      = 4,
  parameter int DMA_STB_LEN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [STAT_W-1:0] req_status_i,
  input  logic [DATA_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  input  logic [DATA_W-1:0] ad_i,
  output logic              ads_n_o,
  output logic              ads_oe_o,
  input  logic              ads_n_i,
  output logic              dir_read_o,
  output logic              dir_oe_o,
  input  logic              dir_read_i,
  output logic              rd_o,
  output logic              wr_o,
  output logic              dbe_o,
  output logic              tso_o,
  output logic [STAT_W-1:0] status_o,
  output logic              status_oe_o,
  input  logic              hold_i,
  output logic              hlda_o
);
  bus_state_e        state_q, state_d;
  logic              cur_write;
  logic [STAT_W-1:0] cur_status;
  logic [DATA_W-1:0] cur_addr, cur_wdata;
  logic              rd_cyc, wr_cyc, rd_dma, wr_dma;

  mbc_seq #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_seq (
    .clk(clk), .rst(rst),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .req_status_i(req_status_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .hold_i(hold_i),
    .state_q(state_q), .state_d(state_d),
    .cur_write(cur_write), .cur_status(cur_status),
    .cur_addr(cur_addr), .cur_wdata(cur_wdata)
  );

  mbc_pins #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_pins (
    .clk(clk), .rst(rst), .state_q(state_q), .state_d(state_d),
    .cur_write(cur_write), .cur_status(cur_status),
    .cur_addr(cur_addr), .cur_wdata(cur_wdata), .ad_i(ad_i),
    .ad_o(ad_o), .ad_oe_o(ad_oe_o), .ads_n_o(ads_n_o), .ads_oe_o(ads_oe_o),
    .dir_read_o(dir_read_o), .dir_oe_o(dir_oe_o),
    .rd_cyc_o(rd_cyc), .wr_cyc_o(wr_cyc), .dbe_o(dbe_o), .tso_o(tso_o),
    .status_o(status_o), .status_oe_o(status_oe_o), .hlda_o(hlda_o),
    .done_o(done_o), .rdata_o(rdata_o)
  );

  mbc_dma #(.STB_LEN(DMA_STB_LEN)) u_dma (
    .clk(clk), .rst(rst),
    .held_q(state_q == BS_HELD), .held_d(state_d == BS_HELD),
    .ads_n_i(ads_n_i), .dir_read_i(dir_read_i),
    .rd_o(rd_dma), .wr_o(wr_dma)
  );

  assign rd_o = rd_cyc | rd_dma;
  assign wr_o = wr_cyc | wr_dma;

  assert_rw_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(rd_o && wr_o));
  assert_ads_bus_R2: assert property (@(posedge clk) disable iff (rst)
    !ads_n_o |-> ad_oe_o);
endmodule

// File: tb/mbc_bus_ctrl_test.sv
module mbc_bus_ctrl_test;
  localparam int W  = 16;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_write = 0, ads_n_in = 1, dir_rd_in = 0, hold = 0;
  logic [SW-1:0] req_status = '0;
  logic [W-1:0]  req_addr = '0, req_wdata = '0, ad_in = '0;
  logic done, ad_oe, ads_n, ads_oe, dir_rd, dir_oe, rd, wr, dbe, tso, st_oe, hlda;
  logic [W-1:0]  rdata, ad_out;
  logic [SW-1:0] status;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mbc_bus_ctrl uut (
    .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_status_i(req_status), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .done_o(done), .rdata_o(rdata), .ad_o(ad_out), .ad_oe_o(ad_oe), .ad_i(ad_in),
    .ads_n_o(ads_n), .ads_oe_o(ads_oe), .ads_n_i(ads_n_in),
    .dir_read_o(dir_rd), .dir_oe_o(dir_oe), .dir_read_i(dir_rd_in),
    .rd_o(rd), .wr_o(wr), .dbe_o(dbe), .tso_o(tso), .status_o(status),
    .status_oe_o(st_oe), .hold_i(hold), .hlda_o(hlda)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // inputs {valid,write,hold,ads_n_i,dir_read_i} | expected {ads_n,rd,wr,dbe,tso,hlda,done,ad_oe}
  localparam logic [12:0] VEC [32] = '{
    13'b10010_00001001, 13'b00010_11010000, 13'b00010_11010000, 13'b00010_10001010,
    13'b00010_10001000, 13'b11010_00001001, 13'b00010_10110001, 13'b00010_10110001,
    13'b10010_10001010, 13'b10010_00001001, 13'b00010_11010000, 13'b00110_11010000,
    13'b00110_10001010, 13'b00110_10001100, 13'b00101_11001100, 13'b00110_11001100,
    13'b00110_10001100, 13'b00100_10101100, 13'b00101_10101100, 13'b00110_10001100,
    13'b10110_10001100, 13'b10010_10001000, 13'b10010_00001001, 13'b00010_11010000,
    13'b00110_11010000, 13'b00110_10001010, 13'b00010_10001000, 13'b10110_10001100,
    13'b00010_10001000, 13'b00001_10001000, 13'b00101_10001100, 13'b00010_10001000
  };

  task automatic do_cycle(input logic w, input logic [SW-1:0] code,
                          input logic [W-1:0] a, input logic [W-1:0] d,
                          input logic [W-1:0] rin);
    req_valid = 1; req_write = w; req_status = code;
    req_addr = a; req_wdata = d; ad_in = rin;
    step();
    req_valid = 0;
    check("R8 status in T1", status, code);
    check("R2 address in T1", {ad_oe, ad_out}, {1'b1, a});
    check(w ? "R5 direction" : "R4 direction", dir_rd, !w);
    step();
    if (w) check("R5 write data in T2", {ad_oe, ad_out}, {1'b1, d});
    else   check("R4 bus released in T2", ad_oe, 0);
    step();
    step();
    check("R7 done in T4", done, 1);
    check("R8 status in T4", status, code);
    if (!w) check("R4 read data", rdata, rin);
    step();
    check("R8 status idle", status, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset outputs",
          {ads_n, rd, wr, dbe, tso, hlda, done, ad_oe, dir_rd, ads_oe, dir_oe, st_oe, 4'(status)},
          {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'h0});
    rst = 0;
    req_addr = 16'hA5C3; req_wdata = 16'h3C5A; req_status = 4'b1100; ad_in = 16'h1234;
    for (int i = 0; i < 32; i++) begin
      {req_valid, req_write, hold, ads_n_in, dir_rd_in} = VEC[i][12:8];
      step();
      check($sformatf("vector %0d (R2 R3 R4 R5 R6 R7 R9 R10 R11 R12)", i),
            {ads_n, rd, wr, dbe, tso, hlda, done, ad_oe}, VEC[i][7:0]);
      if (i == 3) check("R4 rdata in table", rdata, 16'h1234);
    end
    ads_n_in = 1; hold = 0; req_valid = 0;
    do_cycle(1'b0, 4'b1100, 16'h0F0F, 16'h0000, 16'hBEEF);
    do_cycle(1'b1, 4'b1101, 16'hF00D, 16'h55AA, 16'h0000);
    do_cycle(1'b0, 4'b1110, 16'h8001, 16'h0000, 16'h7E81);
    do_cycle(1'b1, 4'b1111, 16'h1357, 16'hC0DE, 16'h0000);
    hold = 1; req_valid = 1;
    step();
    check("R11 enables off while held", {hlda, ads_oe, dir_oe, st_oe, ad_oe}, 5'b10000);
    step();
    check("R11 request ignored while held", {done, ads_n}, 2'b01);
    hold = 0; req_valid = 0;
    step();
    check("R11 enables back after release", {hlda, ads_oe, dir_oe, st_oe}, 4'b0111);
    req_valid = 1; req_write = 1;
    step();
    req_valid = 0;
    step();
    check("R5 write strobe before reset", wr, 1);
    rst = 1;
    step();
    rst = 0;
    check("R1 reset mid-cycle", {ads_n, rd, wr, dbe, tso, done, ad_oe, 4'(status)},
          {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0});
    step();
    check("R1 idle after reset", {ads_n, wr, dbe, done}, 4'b1000);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule